// File: doc/BRIEF.md
# Shared-Bus Register Datapath

This block is the register and interconnect half of a small accumulator machine. A single 16-bit bus links one 4096-word by 16-bit memory port with a set of registers. The registers are a 12-bit address register, a 12-bit program counter, and 16-bit data, accumulator, instruction and temporary registers. An 8-bit input register and an 8-bit output register sit beside them.

A 3-bit source code picks the one value that drives the bus in each cycle. Every destination register has its own enables, and all of them act on the rising clock edge. Because of this, one register can drive the bus while others capture it in the same cycle. The memory address always comes from the address register. Memory write data always comes from the bus.

The accumulator's arithmetic unit and the control sequencer sit outside this block. The sequencer drives the source code and all enables. The external arithmetic unit returns a result word on `alu_result`, and the accumulator loads that word. A character from the input device enters through `in_char`.

Top module: `shared_bus_datapath`

## Requirements
- R1: After reset, all eight registers read zero.
- R2: The bus source codes select as follows: 1 is the address register, 2 the program counter, 3 the data register, 4 the accumulator, 5 the instruction register, 6 the temporary register and 7 the memory word at the current address.
- R3: When the address register or the program counter drives the bus, bus bits 15..12 are zero.
- R4: When a 12-bit register loads from the bus, it takes only bus bits 11..0.
- R5: The output register loads bus bits 7..0. The input register loads `in_char` when its load enable is high.
- R6: The memory address is always the address register. With `mem_wr` high, the bus value is written to that address on the clock edge. The value on the bus (for example the program counter) has no effect on which word is written.
- R7: When its increment enable is high, a counting register adds one and wraps to zero past its all-ones value. The counting registers are the address, program counter, data, accumulator and temporary registers.
- R8: A register's enables take effect in priority order: clear first, then load, then increment.
- R9: A register with no enable asserted holds its value across a clock edge.
- R10: Source code 0 drives all zeros onto the bus.
- R11: With code 7, the bus shows the addressed memory word in the same cycle, with no wait cycle. In one cycle the accumulator can drive the bus into the data register while the accumulator itself loads `alu_result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 3 | Bus source code |
| ar_ld | input | 1 | Address register load from bus |
| ar_inr | input | 1 | Address register increment |
| ar_clr | input | 1 | Address register clear |
| pc_ld | input | 1 | Program counter load from bus |
| pc_inr | input | 1 | Program counter increment |
| pc_clr | input | 1 | Program counter clear |
| dr_ld | input | 1 | Data register load from bus |
| dr_inr | input | 1 | Data register increment |
| dr_clr | input | 1 | Data register clear |
| ac_ld | input | 1 | Accumulator load from alu_result |
| ac_inr | input | 1 | Accumulator increment |
| ac_clr | input | 1 | Accumulator clear |
| tr_ld | input | 1 | Temporary register load from bus |
| tr_inr | input | 1 | Temporary register increment |
| tr_clr | input | 1 | Temporary register clear |
| ir_ld | input | 1 | Instruction register load from bus |
| outr_ld | input | 1 | Output register load from bus low byte |
| inpr_ld | input | 1 | Input register load from in_char |
| mem_wr | input | 1 | Memory write of the bus value |
| alu_result | input | 16 | Result word from the external arithmetic unit |
| in_char | input | 8 | Character from the input device |
| bus | output | 16 | Current bus value |
| ar | output | 12 | Address register |
| pc | output | 12 | Program counter |
| dr | output | 16 | Data register |
| ac | output | 16 | Accumulator |
| ir | output | 16 | Instruction register |
| tr | output | 16 | Temporary register |
| inpr | output | 8 | Input register |
| outr | output | 8 | Output register |

## Verification
A wrong source decode or a missing zero-extension shows up on `bus` in the same cycle that the code is applied. A register that loads, increments or clears wrongly shows a wrong value on its own output port one edge after the enable. A write to the wrong memory word stays hidden until that word, or the word that should have changed, is read back through code 7. For that reason the bench reads back every written word, including one that a misrouted address could have overwritten.

// File: rtl/sbd_pkg.sv
package sbd_pkg;

    typedef enum logic [2:0] {
        SRC_NONE  = 3'd0,
        SRC_ADDR  = 3'd1,
        SRC_PC    = 3'd2,
        SRC_DATA  = 3'd3,
        SRC_ACC   = 3'd4,
        SRC_INSTR = 3'd5,
        SRC_TEMP  = 3'd6,
        SRC_MEM   = 3'd7
    } bus_src_e;

    typedef struct packed {
        logic clr;
        logic ld;
        logic inr;
    } reg_ctrl_t;

endpackage

// File: rtl/sbd_reg.sv
module sbd_reg #(
    parameter int W         = 16,
    parameter bit HAS_COUNT = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  sbd_pkg::reg_ctrl_t    ctl,
    input  logic [W-1:0]          d_in,
    output logic [W-1:0]          q
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] q_d, q_q;

    generate
        if (HAS_COUNT) begin : g_count
            always_comb begin
                q_d = q_q;
                if (ctl.clr)      q_d = '0;
                else if (ctl.ld)  q_d = d_in;
                else if (ctl.inr) q_d = q_q + ONE;
            end

            // R7
            inr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (ctl.inr && !ctl.ld && !ctl.clr) |=> (q == $past(q) + ONE));
            // R8
            clr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ctl.clr |=> (q == '0));
            // R9
            hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!ctl.inr && !ctl.ld && !ctl.clr) |=> $stable(q));
        end else begin : g_load_only
            logic unused_ctl;
            assign unused_ctl = ctl.inr ^ ctl.clr;
            always_comb begin
                q_d = q_q;
                if (ctl.ld) q_d = d_in;
            end

            // R9
            hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !ctl.ld |=> $stable(q));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q = q_q;

    // R8
    load_over_inr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.ld && !(HAS_COUNT && ctl.clr)) |=> (q == $past(d_in)));

endmodule

// File: rtl/sbd_bus_mux.sv
module sbd_bus_mux #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic [2:0]        sel,
    input  logic [ADDR_W-1:0] ar,
    input  logic [ADDR_W-1:0] pc,
    input  logic [WORD_W-1:0] dr,
    input  logic [WORD_W-1:0] ac,
    input  logic [WORD_W-1:0] ir,
    input  logic [WORD_W-1:0] tr,
    input  logic [WORD_W-1:0] mem_rd,
    output logic [WORD_W-1:0] bus
);
    import sbd_pkg::*;

    localparam int PAD_W = WORD_W - ADDR_W;

    logic [WORD_W-1:0] ar_ext, pc_ext;
    assign ar_ext = {{PAD_W{1'b0}}, ar};
    assign pc_ext = {{PAD_W{1'b0}}, pc};

    always_comb begin
        unique case (bus_src_e'(sel))
            SRC_ADDR:  bus = ar_ext;
            SRC_PC:    bus = pc_ext;
            SRC_DATA:  bus = dr;
            SRC_ACC:   bus = ac;
            SRC_INSTR: bus = ir;
            SRC_TEMP:  bus = tr;
            SRC_MEM:   bus = mem_rd;
            default:   bus = '0;
        endcase
    end

endmodule

// File: rtl/sbd_mem.sv
module sbd_mem #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) store_q[addr] <= wdata;
    end

    assign rdata = store_q[addr];

endmodule

// File: rtl/shared_bus_datapath.sv
module shared_bus_datapath #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 12,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_sel,
    input  logic              ar_ld,
    input  logic              ar_inr,
    input  logic              ar_clr,
    input  logic              pc_ld,
    input  logic              pc_inr,
    input  logic              pc_clr,
    input  logic              dr_ld,
    input  logic              dr_inr,
    input  logic              dr_clr,
    input  logic              ac_ld,
    input  logic              ac_inr,
    input  logic              ac_clr,
    input  logic              tr_ld,
    input  logic              tr_inr,
    input  logic              tr_clr,
    input  logic              ir_ld,
    input  logic              outr_ld,
    input  logic              inpr_ld,
    input  logic              mem_wr,
    input  logic [WORD_W-1:0] alu_result,
    input  logic [CHAR_W-1:0] in_char,
    output logic [WORD_W-1:0] bus,
    output logic [ADDR_W-1:0] ar,
    output logic [ADDR_W-1:0] pc,
    output logic [WORD_W-1:0] dr,
    output logic [WORD_W-1:0] ac,
    output logic [WORD_W-1:0] ir,
    output logic [WORD_W-1:0] tr,
    output logic [CHAR_W-1:0] inpr,
    output logic [CHAR_W-1:0] outr
);
    import sbd_pkg::*;

    localparam int PAD_W = WORD_W - ADDR_W;

    logic [WORD_W-1:0] bus_w;
    logic [WORD_W-1:0] mem_rd_w;

    reg_ctrl_t ar_c, pc_c, dr_c, ac_c, tr_c, ir_c, outr_c, inpr_c;

    assign ar_c   = '{clr: ar_clr, ld: ar_ld, inr: ar_inr};
    assign pc_c   = '{clr: pc_clr, ld: pc_ld, inr: pc_inr};
    assign dr_c   = '{clr: dr_clr, ld: dr_ld, inr: dr_inr};
    assign ac_c   = '{clr: ac_clr, ld: ac_ld, inr: ac_inr};
    assign tr_c   = '{clr: tr_clr, ld: tr_ld, inr: tr_inr};
    assign ir_c   = '{clr: 1'b0, ld: ir_ld, inr: 1'b0};
    assign outr_c = '{clr: 1'b0, ld: outr_ld, inr: 1'b0};
    assign inpr_c = '{clr: 1'b0, ld: inpr_ld, inr: 1'b0};

    sbd_reg #(.W(ADDR_W), .HAS_COUNT(1'b1)) u_ar (
        .clk(clk), .rst_n(rst_n), .ctl(ar_c), .d_in(bus_w[ADDR_W-1:0]), .q(ar));
    sbd_reg #(.W(ADDR_W), .HAS_COUNT(1'b1)) u_pc (
        .clk(clk), .rst_n(rst_n), .ctl(pc_c), .d_in(bus_w[ADDR_W-1:0]), .q(pc));
    sbd_reg #(.W(WORD_W), .HAS_COUNT(1'b1)) u_dr (
        .clk(clk), .rst_n(rst_n), .ctl(dr_c), .d_in(bus_w), .q(dr));
    sbd_reg #(.W(WORD_W), .HAS_COUNT(1'b1)) u_ac (
        .clk(clk), .rst_n(rst_n), .ctl(ac_c), .d_in(alu_result), .q(ac));
    sbd_reg #(.W(WORD_W), .HAS_COUNT(1'b1)) u_tr (
        .clk(clk), .rst_n(rst_n), .ctl(tr_c), .d_in(bus_w), .q(tr));
    sbd_reg #(.W(WORD_W), .HAS_COUNT(1'b0)) u_ir (
        .clk(clk), .rst_n(rst_n), .ctl(ir_c), .d_in(bus_w), .q(ir));
    sbd_reg #(.W(CHAR_W), .HAS_COUNT(1'b0)) u_outr (
        .clk(clk), .rst_n(rst_n), .ctl(outr_c), .d_in(bus_w[CHAR_W-1:0]), .q(outr));
    sbd_reg #(.W(CHAR_W), .HAS_COUNT(1'b0)) u_inpr (
        .clk(clk), .rst_n(rst_n), .ctl(inpr_c), .d_in(in_char), .q(inpr));

    sbd_mem #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .wr_en(mem_wr), .addr(ar), .wdata(bus_w), .rdata(mem_rd_w));

    sbd_bus_mux #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_mux (
        .sel(bus_sel), .ar(ar), .pc(pc), .dr(dr), .ac(ac), .ir(ir), .tr(tr),
        .mem_rd(mem_rd_w), .bus(bus_w));

    assign bus = bus_w;

    // R3
    narrow_src_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel == 3'd1 || bus_sel == 3'd2) |-> (bus[WORD_W-1:ADDR_W] == {PAD_W{1'b0}}));
    // R5
    outr_low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        outr_ld |=> (outr == $past(bus[CHAR_W-1:0])));
    // R10
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel == 3'd0) |-> (bus == '0));

endmodule

// File: tb/tb_shared_bus_datapath.sv
`timescale 1ns/100ps
module tb_shared_bus_datapath;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_sel;
    logic ar_ld, ar_inr, ar_clr, pc_ld, pc_inr, pc_clr, dr_ld, dr_inr, dr_clr;
    logic ac_ld, ac_inr, ac_clr, tr_ld, tr_inr, tr_clr, ir_ld, outr_ld, inpr_ld, mem_wr;
    logic [15:0] alu_result;
    logic [7:0]  in_char;
    logic [15:0] bus, dr, ac, ir, tr;
    logic [11:0] ar, pc;
    logic [7:0]  inpr, outr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    shared_bus_datapath dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel),
        .ar_ld(ar_ld), .ar_inr(ar_inr), .ar_clr(ar_clr),
        .pc_ld(pc_ld), .pc_inr(pc_inr), .pc_clr(pc_clr),
        .dr_ld(dr_ld), .dr_inr(dr_inr), .dr_clr(dr_clr),
        .ac_ld(ac_ld), .ac_inr(ac_inr), .ac_clr(ac_clr),
        .tr_ld(tr_ld), .tr_inr(tr_inr), .tr_clr(tr_clr),
        .ir_ld(ir_ld), .outr_ld(outr_ld), .inpr_ld(inpr_ld), .mem_wr(mem_wr),
        .alu_result(alu_result), .in_char(in_char),
        .bus(bus), .ar(ar), .pc(pc), .dr(dr), .ac(ac), .ir(ir), .tr(tr),
        .inpr(inpr), .outr(outr));

    // {address[11:0], data[15:0]}
    localparam logic [27:0] MEM_VEC [6] = '{
        {12'h000, 16'h0001},
        {12'h055, 16'hA5A5},
        {12'h7FF, 16'h8000},
        {12'hFFF, 16'hFFFF},
        {12'h800, 16'h1234},
        {12'h020, 16'h0BAD}
    };

    task automatic idle();
        bus_sel = 3'd0;
        {ar_ld, ar_inr, ar_clr, pc_ld, pc_inr, pc_clr, dr_ld, dr_inr, dr_clr} = '0;
        {ac_ld, ac_inr, ac_clr, tr_ld, tr_inr, tr_clr, ir_ld, outr_ld, inpr_ld, mem_wr} = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_ac(input logic [15:0] v);
        alu_result = v; ac_ld = 1'b1; tick();
    endtask

    task automatic set_ar(input logic [11:0] a);
        load_ac({4'h0, a}); bus_sel = 3'd4; ar_ld = 1'b1; tick();
    endtask

    task automatic write_mem(input logic [11:0] a, input logic [15:0] d);
        set_ar(a); load_ac(d); bus_sel = 3'd4; mem_wr = 1'b1; tick();
    endtask

    initial begin
        idle();
        alu_result = '0;
        in_char = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk("R1 ar", {4'h0, ar}, 16'h0);
        chk("R1 pc", {4'h0, pc}, 16'h0);
        chk("R1 dr", dr, 16'h0);
        chk("R1 ac", ac, 16'h0);
        chk("R1 ir", ir, 16'h0);
        chk("R1 tr", tr, 16'h0);
        chk("R1 inpr/outr", {inpr, outr}, 16'h0);

        // Populate registers through the bus, driven from the accumulator
        load_ac(16'h7E5A); bus_sel = 3'd4; tr_ld = 1'b1; tick();
        load_ac(16'hC3F0); bus_sel = 3'd4; ir_ld = 1'b1; tick();
        load_ac(16'hFABC); bus_sel = 3'd4; pc_ld = 1'b1; tick();
        load_ac(16'h9123); bus_sel = 3'd4; ar_ld = 1'b1; tick();
        load_ac(16'h5A5A); bus_sel = 3'd4; dr_ld = 1'b1; tick();
        load_ac(16'h0F0F);

        // R4 truncation of 12-bit loads
        chk("R4 pc trunc", {4'h0, pc}, 16'h0ABC);
        chk("R4 ar trunc", {4'h0, ar}, 16'h0123);

        // R10 code 0 is all zeros
        bus_sel = 3'd0; #1; chk("R10 sel0", bus, 16'h0000);
        // R2 / R3 source decode and zero extension
        bus_sel = 3'd1; #1; chk("R3 R2 sel1 ar", bus, 16'h0123);
        bus_sel = 3'd2; #1; chk("R3 R2 sel2 pc", bus, 16'h0ABC);
        bus_sel = 3'd3; #1; chk("R2 sel3 dr", bus, 16'h5A5A);
        bus_sel = 3'd4; #1; chk("R2 sel4 ac", bus, 16'h0F0F);
        bus_sel = 3'd5; #1; chk("R2 sel5 ir", bus, 16'hC3F0);
        bus_sel = 3'd6; #1; chk("R2 sel6 tr", bus, 16'h7E5A);
        idle();

        // R9 hold with no enables, even with inputs moving
        alu_result = 16'hDEAD; in_char = 8'h99; bus_sel = 3'd7; tick();
        chk("R9 ac hold", ac, 16'h0F0F);
        chk("R9 dr hold", dr, 16'h5A5A);
        chk("R9 ir hold", ir, 16'hC3F0);
        chk("R9 inpr hold", {8'h0, inpr}, 16'h0000);

        // R5 byte-wide registers
        load_ac(16'h1234); bus_sel = 3'd4; outr_ld = 1'b1; tick();
        chk("R5 outr low byte", {8'h0, outr}, 16'h0034);
        in_char = 8'hA7; inpr_ld = 1'b1; tick();
        chk("R5 inpr", {8'h0, inpr}, 16'h00A7);

        // R7 increment and wrap
        pc_inr = 1'b1; tick();
        chk("R7 pc inc", {4'h0, pc}, 16'h0ABD);
        load_ac(16'hFFFF); bus_sel = 3'd4; pc_ld = 1'b1; tick();
        pc_inr = 1'b1; tick();
        chk("R7 pc wrap", {4'h0, pc}, 16'h0000);
        ac_inr = 1'b1; tr_inr = 1'b1; tick();
        chk("R7 ac wrap", ac, 16'h0000);
        chk("R7 tr inc", tr, 16'h7E5B);

        // R8 priority
        load_ac(16'h0040);
        bus_sel = 3'd4; ar_ld = 1'b1; ar_clr = 1'b1; ar_inr = 1'b1; tick();
        chk("R8 clr over ld", {4'h0, ar}, 16'h0000);
        bus_sel = 3'd4; dr_ld = 1'b1; dr_inr = 1'b1; tick();
        chk("R8 ld over inr", dr, 16'h0040);

        // R11 same-cycle exchange: DR <- AC over the bus, AC <- result
        load_ac(16'h2468); bus_sel = 3'd4; dr_ld = 1'b1; tick();
        load_ac(16'h1357);
        bus_sel = 3'd4; dr_ld = 1'b1; alu_result = 16'h2468; ac_ld = 1'b1; tick();
        chk("R11 exchange dr", dr, 16'h1357);
        chk("R11 exchange ac", ac, 16'h2468);

        // R6 memory writes driven by the table
        foreach (MEM_VEC[i]) write_mem(MEM_VEC[i][27:16], MEM_VEC[i][15:0]);

        // R6 address from AR only: PC on the bus is data, not address
        load_ac(16'h0055); bus_sel = 3'd4; pc_ld = 1'b1; tick();
        set_ar(12'h020);
        bus_sel = 3'd2; mem_wr = 1'b1; tick();

        // R6 / R11 read back every word
        foreach (MEM_VEC[i]) begin
            logic [15:0] exp_w;
            exp_w = (MEM_VEC[i][27:16] == 12'h020) ? 16'h0055 : MEM_VEC[i][15:0];
            set_ar(MEM_VEC[i][27:16]);
            bus_sel = 3'd7; #1;
            chk("R11 mem on bus", bus, exp_w);
            dr_ld = 1'b1; tick();
            chk("R6 mem into dr", dr, exp_w);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule